// File: doc/BRIEF.md
# SPI Slave with Persistent Transmit Ring

This block is a slave-only serial peripheral interface endpoint for a system-clocked chip. An external master supplies the serial clock and an active-low chip select. Every transfer is a 16-bit word in clock mode 1: the clock idles low, each bit is launched on a rising edge and sampled on a falling edge, most significant bit first. The slave has no way to tell that the master has restarted. It simply shifts whenever it is clocked.

The local side writes outgoing words into an eight-slot transmit ring and reads received words from a receive FIFO. An enable input gates all serial activity. Clearing the enable does not flush the transmit ring: its slots, pointers and count are kept, and shifting resumes from the leftover words once the enable returns.

When a frame begins and the ring holds no queued word, the slave replays the word stored in the slot under the read pointer. After the ring has wrapped, that slot holds the eighth most recent write. Leftover words can only be removed in two ways: the master clocks dummy frames, each of which consumes one queued word, or the synchronous reset is asserted. The serial inputs pass through two-flop synchronizers, so the system clock must run at least eight times faster than the serial clock.

Top module: `spi_slave_ring`

## Requirements
- R1: Each frame is 16 bits, sent and received most significant bit first. MISO changes after a rising serial clock edge, and MOSI is captured on the falling edge.
- R2: The transmit ring holds 8 words. Once 8 words are held, `tx_not_full` is low and a further `tx_push` is dropped without altering the ring.
- R3: Queued transmit words leave in push order. Each frame clocked while the block is enabled consumes exactly one queued word, if one is present.
- R4: If no word is queued when a word is loaded for a frame, the slave sends the word in the slot under the read pointer (the eighth most recent write after a wrap), and the ring count and `tx_empty` stay unchanged.
- R5: While `en` is low, serial clock and chip select activity is ignored: nothing is received and no transmit word is consumed. When `en` is high again, transmission continues from the leftover contents.
- R6: A transmit word is loaded when chip select asserts, unless a word loaded at the end of a previous frame is still waiting to be sent. A word is also loaded at every 16-bit frame end, so back-to-back frames under one chip select carry consecutive words.
- R7: Received words are read in arrival order from `rx_data`. `rx_pop` removes the head word. `rx_not_empty` is high while words are present, and `rx_full` is high when 8 words are held.
- R8: A word that completes while the receive FIFO is full is discarded and sets `rx_overrun`. The flag then stays high until reset.
- R9: Synchronous reset `rst` empties both FIFOs, zeroes the transmit slots and the shift registers, and clears `rx_overrun`. A frame clocked after reset with nothing queued therefore sends 0x0000.
- R10: MISO is driven low whenever chip select has been inactive for at least three system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Serial engine enable |
| sclk | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low chip select from the master |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| tx_push | input | 1 | Write `tx_data` into the transmit ring |
| tx_data | input | 16 | Word to transmit |
| tx_empty | output | 1 | Transmit ring holds no queued word |
| tx_not_full | output | 1 | Transmit ring can accept a word |
| rx_pop | input | 1 | Remove the head word of the receive FIFO |
| rx_data | output | 16 | Head word of the receive FIFO |
| rx_not_empty | output | 1 | Receive FIFO holds at least one word |
| rx_full | output | 1 | Receive FIFO holds 8 words |
| rx_overrun | output | 1 | Sticky flag: a received word was dropped |

## Verification
The hardest case to reach from the ports is the replay of a stale slot after the ring has wrapped. It needs a full ring, a rejected ninth push, and more clocked frames than there are queued words, all without a reset. The stimulus fills the ring and then clocks ten frames under one chip select. This drains the eight queued words, exercises the preload made at each frame end, replays the stale slot, and overruns the receive FIFO in the same burst. A bench model of the ring, including the pending-word flag, predicts the word each frame must carry.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;

    localparam int unsigned FRAME_W  = 16;
    localparam int unsigned TX_DEPTH = 8;
    localparam int unsigned RX_DEPTH = 8;

    // Serial-side events after synchronisation, one system clock wide.
    typedef struct packed {
        logic rise;    // serial clock rising edge
        logic fall;    // serial clock falling edge
        logic active;  // chip select asserted (level)
        logic start;   // chip select just asserted
        logic mosi;    // synchronised data in
    } spi_evt_t;

    typedef struct packed {
        logic empty;
        logic full;
    } fifo_flags_t;

    // Advance a ring index with wrap at depth.
    function automatic int unsigned ring_next(int unsigned idx, int unsigned depth);
        return (idx == depth - 1) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync
    import spi_slv_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sclk,
    input  logic     cs_n,
    input  logic     mosi,
    output spi_evt_t evt
);
    // Two synchroniser stages plus one history stage for edge detection.
    logic [2:0] sclk_q;
    logic [2:0] csn_q;
    logic [1:0] mosi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= '0;
            csn_q  <= '1;
            mosi_q <= '0;
        end else begin
            sclk_q <= {sclk_q[1:0], sclk};
            csn_q  <= {csn_q[1:0], cs_n};
            mosi_q <= {mosi_q[0], mosi};
        end
    end

    always_comb begin
        evt.rise   =  sclk_q[1] & ~sclk_q[2];
        evt.fall   = ~sclk_q[1] &  sclk_q[2];
        evt.active = ~csn_q[1];
        evt.start  = ~csn_q[1] &  csn_q[2];
        evt.mosi   =  mosi_q[1];
    end

endmodule

// File: rtl/spi_ring_fifo.sv
module spi_ring_fifo
    import spi_slv_pkg::*;
#(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output fifo_flags_t      flags
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] slot [DEPTH];
    logic [AW-1:0]    rd_idx;
    logic [AW-1:0]    wr_idx;
    logic [CW-1:0]    count;
    logic             do_push;
    logic             do_pop;

    always_comb begin
        flags.empty = (count == '0);
        flags.full  = (count == CW'(DEPTH));
        do_push     = push & ~flags.full;
        do_pop      = pop  & ~flags.empty;
        // The read slot is always visible, queued or not.
        head        = slot[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_idx <= '0;
            wr_idx <= '0;
            count  <= '0;
            for (int i = 0; i < int'(DEPTH); i++) begin
                slot[i] <= '0;
            end
        end else begin
            if (do_push) begin
                slot[wr_idx] <= wdata;
                wr_idx       <= AW'(ring_next(int'(wr_idx), DEPTH));
            end
            if (do_pop) begin
                rd_idx <= AW'(ring_next(int'(rd_idx), DEPTH));
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_slv_pkg::*;
#(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  spi_evt_t         evt,
    input  logic [WIDTH-1:0] load_word,
    output logic             load_req,
    output logic [WIDTH-1:0] rx_word,
    output logic             rx_valid,
    output logic             miso
);
    localparam int unsigned BW = $clog2(WIDTH);

    logic [WIDTH-1:0] tx_sh;
    logic [WIDTH-1:0] rx_sh;
    logic [BW-1:0]    bit_cnt;
    logic             primed;   // a loaded word is waiting for its first bit
    logic             miso_q;
    logic             live;
    logic             frame_end;

    always_comb begin
        live      = en & evt.active;
        frame_end = live & evt.fall & (bit_cnt == BW'(WIDTH - 1));
        load_req  = (en & evt.start & ~primed) | frame_end;
        rx_word   = {rx_sh[WIDTH-2:0], evt.mosi};
        rx_valid  = frame_end;
        miso      = miso_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sh   <= '0;
            rx_sh   <= '0;
            bit_cnt <= '0;
            primed  <= 1'b0;
            miso_q  <= 1'b0;
        end else begin
            if (!evt.active) begin
                bit_cnt <= '0;
                miso_q  <= 1'b0;
            end else if (en) begin
                if (evt.rise) begin
                    miso_q <= tx_sh[WIDTH-1];
                    tx_sh  <= {tx_sh[WIDTH-2:0], 1'b0};
                    if (bit_cnt == '0) begin
                        primed <= 1'b0;
                    end
                end
                if (evt.fall) begin
                    rx_sh   <= {rx_sh[WIDTH-2:0], evt.mosi};
                    bit_cnt <= frame_end ? '0 : bit_cnt + 1'b1;
                end
            end
            if (load_req) begin
                tx_sh  <= load_word;
                primed <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/spi_slave_ring.sv
module spi_slave_ring
    import spi_slv_pkg::*;
#(
    parameter int unsigned FW    = FRAME_W,
    parameter int unsigned TX_N  = TX_DEPTH,
    parameter int unsigned RX_N  = RX_DEPTH
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          sclk,
    input  logic          cs_n,
    input  logic          mosi,
    output logic          miso,
    input  logic          tx_push,
    input  logic [FW-1:0] tx_data,
    output logic          tx_empty,
    output logic          tx_not_full,
    input  logic          rx_pop,
    output logic [FW-1:0] rx_data,
    output logic          rx_not_empty,
    output logic          rx_full,
    output logic          rx_overrun
);
    spi_evt_t    evt;
    fifo_flags_t tx_flags;
    fifo_flags_t rx_flags;
    logic [FW-1:0] tx_head;
    logic [FW-1:0] rx_word;
    logic          load_req;
    logic          rx_valid;
    logic          ovr_q;

    spi_edge_sync u_sync (
        .clk  (clk),
        .rst  (rst),
        .sclk (sclk),
        .cs_n (cs_n),
        .mosi (mosi),
        .evt  (evt)
    );

    spi_shift_engine #(.WIDTH(FW)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .evt       (evt),
        .load_word (tx_head),
        .load_req  (load_req),
        .rx_word   (rx_word),
        .rx_valid  (rx_valid),
        .miso      (miso)
    );

    // A load on an empty ring reads the stale slot; the pop is refused inside.
    spi_ring_fifo #(.WIDTH(FW), .DEPTH(TX_N)) u_tx_ring (
        .clk   (clk),
        .rst   (rst),
        .push  (tx_push),
        .wdata (tx_data),
        .pop   (load_req),
        .head  (tx_head),
        .flags (tx_flags)
    );

    spi_ring_fifo #(.WIDTH(FW), .DEPTH(RX_N)) u_rx_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (rx_valid),
        .wdata (rx_word),
        .pop   (rx_pop),
        .head  (rx_data),
        .flags (rx_flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ovr_q <= 1'b0;
        end else if (rx_valid && rx_flags.full) begin
            ovr_q <= 1'b1;
        end
    end

    always_comb begin
        tx_empty     = tx_flags.empty;
        tx_not_full  = ~tx_flags.full;
        rx_not_empty = ~rx_flags.empty;
        rx_full      = rx_flags.full;
        rx_overrun   = ovr_q;
    end

endmodule

// File: rtl/spi_slave_ring_chk.sv
module spi_slave_ring_chk (
    input logic clk,
    input logic rst,
    input logic en,
    input logic cs_n,
    input logic miso,
    input logic tx_push,
    input logic tx_empty,
    input logic tx_not_full,
    input logic rx_not_empty,
    input logic rx_full,
    input logic rx_overrun
);
    // R8: overrun flag is sticky
    a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        rx_overrun |=> rx_overrun);

    // R7: full implies data present
    a_r7_full_has_data: assert property (@(posedge clk) disable iff (rst)
        rx_full |-> rx_not_empty);

    // R5: nothing arrives while disabled
    a_r5_no_rx_when_off: assert property (@(posedge clk) disable iff (rst)
        !en |=> !$rose(rx_not_empty));

    // R2: a full ring stays full while disabled, pushes are dropped
    a_r2_full_held_off: assert property (@(posedge clk) disable iff (rst)
        (!en && !tx_not_full) |=> !tx_not_full);

    // R4: a stale replay leaves the ring empty
    a_r4_replay_keeps_empty: assert property (@(posedge clk) disable iff (rst)
        (tx_empty && !tx_push) |=> tx_empty);

    // R10: MISO low when chip select idle
    a_r10_miso_idle: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !miso);

    // R9: reset clears the flags
    a_r9_reset_state: assert property (@(posedge clk)
        rst |=> (tx_empty && tx_not_full && !rx_not_empty && !rx_overrun));

endmodule

bind spi_slave_ring spi_slave_ring_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .en           (en),
    .cs_n         (cs_n),
    .miso         (miso),
    .tx_push      (tx_push),
    .tx_empty     (tx_empty),
    .tx_not_full  (tx_not_full),
    .rx_not_empty (rx_not_empty),
    .rx_full      (rx_full),
    .rx_overrun   (rx_overrun)
);

// File: tb/tb_spi_slave_ring.sv
module tb_spi_slave_ring;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b1;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        mosi = 1'b0;
    logic        miso;
    logic        tx_push = 1'b0;
    logic [15:0] tx_data = '0;
    logic        tx_empty;
    logic        tx_not_full;
    logic        rx_pop = 1'b0;
    logic [15:0] rx_data;
    logic        rx_not_empty;
    logic        rx_full;
    logic        rx_overrun;

    always #5 clk = ~clk;

    spi_slave_ring dut (
        .clk(clk), .rst(rst), .en(en), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .tx_push(tx_push), .tx_data(tx_data), .tx_empty(tx_empty),
        .tx_not_full(tx_not_full), .rx_pop(rx_pop), .rx_data(rx_data),
        .rx_not_empty(rx_not_empty), .rx_full(rx_full), .rx_overrun(rx_overrun)
    );

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // Reference model of the transmit ring and receive FIFO.
    logic [15:0] m_mem [8];
    int          m_rd, m_wr, m_cnt;
    bit          m_primed;
    bit          m_ovr;
    logic [15:0] exp_tx [$];
    logic [15:0] exp_rx [$];

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 8; i++) m_mem[i] = '0;
        m_rd = 0; m_wr = 0; m_cnt = 0;
        m_primed = 1'b0; m_ovr = 1'b0;
        exp_tx.delete(); exp_rx.delete();
    endtask

    task automatic model_load();
        exp_tx.push_back(m_mem[m_rd]);
        if (m_cnt > 0) begin
            m_rd = (m_rd + 1) % 8;
            m_cnt--;
        end
        m_primed = 1'b1;
    endtask

    task automatic wait_half();
        repeat (8) @(posedge clk);
        #1;
    endtask

    task automatic push_word(logic [15:0] w);
        tx_push = 1'b1; tx_data = w;
        @(posedge clk); #1;
        tx_push = 1'b0;
        if (m_cnt < 8) begin
            m_mem[m_wr] = w;
            m_wr = (m_wr + 1) % 8;
            m_cnt++;
        end
    endtask

    // Driver: clocks n frames under one chip select; the scoreboard queue
    // holds the word each frame must carry and is popped at frame end.
    task automatic burst(int n, logic [15:0] base, string tag);
        bit on;
        on = en;
        cs_n = 1'b0;
        if (on && !m_primed) model_load();
        wait_half();
        for (int f = 0; f < n; f++) begin
            logic [15:0] w;
            logic [15:0] got;
            logic [15:0] want;
            w = base + 16'(f);
            got = '0;
            for (int b = 15; b >= 0; b--) begin
                sclk = 1'b1; mosi = w[b];
                if (on && b == 15) m_primed = 1'b0;
                wait_half();
                got[b] = miso;
                sclk = 1'b0;
                wait_half();
            end
            if (on) begin
                if (exp_rx.size() < 8) exp_rx.push_back(w);
                else m_ovr = 1'b1;
                want = exp_tx.pop_front();
                model_load();
                check(got == want, tag, 32'(got), 32'(want));
            end
        end
        cs_n = 1'b1;
        wait_half();
    endtask

    // Monitor side of the receive path.
    task automatic drain(string tag);
        while (exp_rx.size() > 0) begin
            logic [15:0] want;
            want = exp_rx.pop_front();
            check(rx_not_empty == 1'b1, tag, 32'(rx_not_empty), 32'd1);
            check(rx_data == want, tag, 32'(rx_data), 32'(want));
            rx_pop = 1'b1;
            @(posedge clk); #1;
            rx_pop = 1'b0;
        end
        check(rx_not_empty == 1'b0, tag, 32'(rx_not_empty), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (6) @(posedge clk);
        #1 rst = 1'b0;
        @(posedge clk); #1;
        // R9 reset state
        check(tx_empty == 1'b1, "R9 tx_empty", 32'(tx_empty), 32'd1);
        check(tx_not_full == 1'b1, "R9 tx_not_full", 32'(tx_not_full), 32'd1);
        check(rx_not_empty == 1'b0, "R9 rx_not_empty", 32'(rx_not_empty), 32'd0);
        check(rx_overrun == 1'b0, "R9 rx_overrun", 32'(rx_overrun), 32'd0);
        check(miso == 1'b0, "R10 miso idle", 32'(miso), 32'd0);

        // R9/R4: empty ring after reset sends the zeroed slot
        burst(1, 16'hA5C3, "R9 R4 R1 frame after reset");
        drain("R7 R1 rx order");

        // R6/R3: back-to-back frames under one chip select
        push_word(16'hC001); push_word(16'hC002);
        push_word(16'h8000); push_word(16'h0001);
        burst(5, 16'h1230, "R6 R3 R1 back-to-back");
        check(tx_empty == 1'b1, "R3 drained", 32'(tx_empty), 32'd1);
        drain("R7 rx after burst");

        // R2: fill ring, ninth push dropped
        for (int i = 0; i < 8; i++) push_word(16'hD000 + 16'(i));
        check(tx_not_full == 1'b0, "R2 full flag", 32'(tx_not_full), 32'd0);
        push_word(16'hDEAD);
        check(tx_not_full == 1'b0, "R2 still full", 32'(tx_not_full), 32'd0);
        // R4/R8: drain past empty, replay stale slot, overrun receive side
        burst(10, 16'h4000, "R4 R2 R3 wrap and replay");
        check(tx_empty == 1'b1, "R4 empty after replay", 32'(tx_empty), 32'd1);
        check(rx_full == 1'b1, "R7 rx_full", 32'(rx_full), 32'd1);
        check(rx_overrun == m_ovr, "R8 overrun set", 32'(rx_overrun), 32'(m_ovr));
        drain("R7 R8 rx kept words");
        check(rx_overrun == 1'b1, "R8 overrun sticky", 32'(rx_overrun), 32'd1);

        // R5: disabled frames are ignored, leftover data survives
        push_word(16'hE0E0); push_word(16'hE1E1); push_word(16'hE2E2);
        en = 1'b0;
        burst(2, 16'h7700, "R5 disabled");
        check(rx_not_empty == 1'b0, "R5 no rx while off", 32'(rx_not_empty), 32'd0);
        check(tx_empty == 1'b0, "R5 tx kept", 32'(tx_empty), 32'd0);
        en = 1'b1;
        @(posedge clk); #1;
        burst(4, 16'h5500, "R5 R3 resume leftovers");
        drain("R7 rx after resume");

        // R6: single frames with chip select toggling
        push_word(16'hF00F); push_word(16'h0FF0);
        burst(1, 16'h2222, "R6 single frame a");
        check(miso == 1'b0, "R10 miso idle after frame", 32'(miso), 32'd0);
        burst(1, 16'h3333, "R6 single frame b");
        drain("R7 rx single frames");

        // R9: reset flushes queued data and clears overrun
        push_word(16'h9999); push_word(16'h8888);
        rst = 1'b1;
        repeat (3) @(posedge clk); #1;
        rst = 1'b0;
        model_reset();
        @(posedge clk); #1;
        check(tx_empty == 1'b1, "R9 flush tx", 32'(tx_empty), 32'd1);
        check(rx_overrun == 1'b0, "R9 clear overrun", 32'(rx_overrun), 32'd0);
        burst(1, 16'h6666, "R9 R4 frame after second reset");
        drain("R7 rx after reset");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule